// File: doc/BRIEF.md
# Power-Good Window Monitor

This block decides whether a regulated output is in regulation. It compares a digitized feedback code against a reference code using two windows. A narrow window qualifies entry into power-good, and a wider window, with hysteresis, governs exit. Power-good is granted only after the feedback has stayed inside the narrow window for a qualification time counted in microsecond ticks. It is withdrawn once the feedback has stayed outside the wide window for more than one switching cycle, counted in switching-cycle ticks.

A display-select bit routes the power-good state onto an interrupt pin. During startup that pin is held asserted until power-good is first qualified. A mask bit suppresses both the power-good output and the interrupt indication, while the internal state keeps tracking. The analog comparators that would normally produce the window decisions are replaced by fixed-point arithmetic on the two codes.

Top module: `pwrgood_monitor`

## Requirements
- R1: The narrow window covers every fbCode with |fbCode − refCode| ≤ floor(refCode·ENTRY_PCT/100), with both limits inclusive. ENTRY_PCT defaults to 5.
- R2: While power-good is low, pgOut rises one clock after the DWELL_US-th usTick pulse seen with feedback in the narrow window, and not before. The window decision is registered, so a usTick counts only from the second clock edge after fbCode changes.
- R3: If feedback leaves the narrow window before qualification completes, the dwell count restarts from zero.
- R4: The wide window covers |fbCode − refCode| ≤ floor(refCode·EXIT_PCT/100), with both limits inclusive (EXIT_PCT defaults to 7). While power-good is high and feedback is inside the wide window, power-good stays high, including feedback outside the narrow window.
- R5: While power-good is high and feedback is outside the wide window, power-good clears on the (EXIT_CYCLES+1)-th cycleTick, that is, the second tick by default. Returning inside the wide window resets this count.
- R6: When dispSel is 1 and mask is 0, intPin equals the power-good state.
- R7: When startup is 1 and mask is 0, intPin is 1 until power-good has been qualified.
- R8: When mask is 1, pgOut and intPin are both 0. Qualification continues internally, so clearing mask shows the tracked state at once.
- R9: Reset (rstN low) and enable low both force power-good to 0 and clear both counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Regulation enabled; 0 clears power-good |
| fbCode | input | DATA_W | Digitized feedback value |
| refCode | input | DATA_W | Digitized reference value |
| cycleTick | input | 1 | One-clock pulse per switching cycle |
| usTick | input | 1 | One-clock pulse per microsecond |
| startup | input | 1 | Startup in progress |
| mask | input | 1 | 1 suppresses power-good action and indication |
| dispSel | input | 1 | 1 shows power-good on intPin |
| pgOut | output | 1 | Power-good status |
| intPin | output | 1 | Interrupt pin level |

## Verification
A new fbCode reaches the window flags at the next clock edge. The tick that completes a count changes pgState at the edge where that tick is sampled. pgOut and intPin follow pgState, mask, dispSel and startup combinationally. The bench therefore drives all inputs on falling edges, waits two clocks after each fbCode change before issuing any tick, and samples one falling edge after the last tick pulse. Each sweep point is checked twice, once just before and once on the deciding tick, so an early or late count is caught as well as a wrong window.

// File: rtl/pg_monitor_pkg.sv
package pg_monitor_pkg;
  // Window decisions passed from datapath to control
  typedef struct packed {
    logic inNarrow;
    logic inWide;
  } pg_win_t;
endpackage

// File: rtl/pg_window_dp.sv
module pg_window_dp
  import pg_monitor_pkg::*;
#(
  parameter int DATA_W    = 10,
  parameter int ENTRY_PCT = 5,
  parameter int EXIT_PCT  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] fbCode,
  input  logic [DATA_W-1:0] refCode,
  output pg_win_t           win
);
  localparam int PROD_W = DATA_W + 8;
  localparam int SUM_W  = DATA_W + 2;
  localparam int PCT [2] = '{ENTRY_PCT, EXIT_PCT};

  logic [1:0] hit;
  logic [1:0] hitQ;

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : gWin
      logic [PROD_W-1:0] prod;
      logic [SUM_W-1:0]  dev;
      logic [SUM_W-1:0]  fbExt;
      logic [SUM_W-1:0]  refExt;
      always_comb begin
        prod   = PROD_W'(refCode) * PROD_W'(PCT[g]);
        dev    = SUM_W'(prod / PROD_W'(100));
        fbExt  = SUM_W'(fbCode);
        refExt = SUM_W'(refCode);
        // inclusive limits written without subtraction to avoid underflow
        hit[g] = (fbExt + dev >= refExt) && (fbExt <= refExt + dev);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hitQ <= '0;
    else       hitQ <= hit;
  end

  assign win.inNarrow = hitQ[0];
  assign win.inWide   = hitQ[1];
endmodule

// File: rtl/pg_ctrl.sv
module pg_ctrl
  import pg_monitor_pkg::*;
#(
  parameter int DWELL_US    = 3300,
  parameter int EXIT_CYCLES = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    usTick,
  input  logic    cycleTick,
  input  pg_win_t win,
  output logic    pgState
);
  localparam int DW_W = $clog2(DWELL_US + 1);
  localparam int EX_W = $clog2(EXIT_CYCLES + 2);

  logic [DW_W-1:0] dwellCnt;
  logic [EX_W-1:0] exitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pgState  <= 1'b0;
      dwellCnt <= '0;
      exitCnt  <= '0;
    end else if (!enable) begin
      pgState  <= 1'b0;
      dwellCnt <= '0;
      exitCnt  <= '0;
    end else if (!pgState) begin
      exitCnt <= '0;
      if (!win.inNarrow) begin
        dwellCnt <= '0;
      end else if (usTick) begin
        if (dwellCnt == DW_W'(DWELL_US - 1)) begin
          pgState  <= 1'b1;
          dwellCnt <= '0;
        end else begin
          dwellCnt <= dwellCnt + 1'b1;
        end
      end
    end else begin
      dwellCnt <= '0;
      if (win.inWide) begin
        exitCnt <= '0;
      end else if (cycleTick) begin
        if (exitCnt == EX_W'(EXIT_CYCLES)) begin
          pgState <= 1'b0;
          exitCnt <= '0;
        end else begin
          exitCnt <= exitCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pwrgood_monitor.sv
module pwrgood_monitor
  import pg_monitor_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int DWELL_US    = 3300,
  parameter int ENTRY_PCT   = 5,
  parameter int EXIT_PCT    = 7,
  parameter int EXIT_CYCLES = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [DATA_W-1:0] fbCode,
  input  logic [DATA_W-1:0] refCode,
  input  logic              cycleTick,
  input  logic              usTick,
  input  logic              startup,
  input  logic              mask,
  input  logic              dispSel,
  output logic              pgOut,
  output logic              intPin
);
  pg_win_t win;
  logic    pgState;

  pg_window_dp #(.DATA_W(DATA_W), .ENTRY_PCT(ENTRY_PCT), .EXIT_PCT(EXIT_PCT)) uDp (
    .clk(clk), .rstN(rstN), .fbCode(fbCode), .refCode(refCode), .win(win)
  );

  pg_ctrl #(.DWELL_US(DWELL_US), .EXIT_CYCLES(EXIT_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .usTick(usTick),
    .cycleTick(cycleTick), .win(win), .pgState(pgState)
  );

  assign pgOut  = pgState & ~mask;
  assign intPin = ~mask & ((startup & ~pgState) | (dispSel & pgState));
endmodule

// File: rtl/pg_monitor_chk.sv
module pg_monitor_chk
  import pg_monitor_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    enable,
  input logic    startup,
  input logic    mask,
  input logic    pgState,
  input logic    pgOut,
  input logic    intPin,
  input pg_win_t win
);
  // R9: disabling clears power-good at the next edge
  assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !pgState);

  // R2: qualification only completes from inside the narrow window
  assert_rise_from_narrow_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pgState) |-> $past(win.inNarrow));

  // R3: no qualification while outside the narrow window
  assert_hold_low_outside_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!pgState && !win.inNarrow) |=> !pgState);

  // R4: inside the wide window with regulation on, power-good is kept
  assert_keep_in_wide_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pgState && win.inWide && enable) |=> pgState);

  // R5: a drop while enabled needs an excursion outside the wide window
  assert_fall_needs_exit_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(pgState) && $past(enable)) |-> !$past(win.inWide));

  // R8: masked means nothing is shown
  assert_mask_silences_R8: assert property (@(posedge clk) disable iff (!rstN)
    mask |-> (!pgOut && !intPin));

  // R7: startup holds the pin until qualified
  assert_startup_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (startup && !mask && !pgState) |-> intPin);
endmodule

bind pwrgood_monitor pg_monitor_chk uChk (
  .clk(clk), .rstN(rstN), .enable(enable), .startup(startup), .mask(mask),
  .pgState(pgState), .pgOut(pgOut), .intPin(intPin), .win(win)
);

// File: tb/pwrgood_monitor_test.sv
`timescale 1ns/1ps
module pwrgood_monitor_test;
  localparam int DATA_W = 10;
  localparam int DWELL  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [DATA_W-1:0] fbCode = '0;
  logic [DATA_W-1:0] refCode = '0;
  logic cycleTick = 1'b0, usTick = 1'b0, startup = 1'b0, mask = 1'b0, dispSel = 1'b0;
  logic pgOut, intPin;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwrgood_monitor #(.DATA_W(DATA_W), .DWELL_US(DWELL), .ENTRY_PCT(5),
                    .EXIT_PCT(7), .EXIT_CYCLES(1)) uut (
    .clk(clk), .rstN(rstN), .enable(enable), .fbCode(fbCode), .refCode(refCode),
    .cycleTick(cycleTick), .usTick(usTick), .startup(startup), .mask(mask),
    .dispSel(dispSel), .pgOut(pgOut), .intPin(intPin)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseUs(input int n);
    repeat (n) begin
      usTick = 1'b1; @(negedge clk); usTick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic pulseCyc(input int n);
    repeat (n) begin
      cycleTick = 1'b1; @(negedge clk); cycleTick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic restart();
    enable = 1'b0; waitN(1); enable = 1'b1; waitN(1);
  endtask

  task automatic setFb(input int v);
    fbCode = DATA_W'(v); waitN(2);
  endtask

  function automatic bit inWin(input int fb, input int rf, input int pct);
    int d = (fb > rf) ? fb - rf : rf - fb;
    return (100 * d) <= (pct * rf);
  endfunction

  initial begin
    int refs [3] = '{100, 350, 900};
    waitN(3);
    check("R9 reset pgOut", pgOut, 1'b0);
    check("R9 reset intPin", intPin, 1'b0);
    rstN = 1'b1; enable = 1'b1;

    // R1/R2 sweep of the narrow window with dwell timing
    foreach (refs[i]) begin
      int rf = refs[i];
      int span = rf / 10 + 2;
      refCode = DATA_W'(rf);
      for (int fb = rf - span; fb <= rf + span; fb++) begin
        restart();
        setFb(fb);
        pulseUs(DWELL - 1);
        check("R2 not before dwell", pgOut, 1'b0);
        pulseUs(1);
        check("R1 narrow window", pgOut, inWin(fb, rf, 5));
      end
    end

    // R4/R5 sweep of the wide window with exit timing
    foreach (refs[i]) begin
      int rf = refs[i];
      int span = rf / 10 + 2;
      refCode = DATA_W'(rf);
      for (int fb = rf - span; fb <= rf + span; fb++) begin
        restart();
        setFb(rf);
        pulseUs(DWELL);
        setFb(fb);
        pulseCyc(1);
        check("R5 one cycle not enough", pgOut, 1'b1);
        pulseCyc(1);
        check("R4 wide window", pgOut, inWin(fb, rf, 7));
      end
    end

    // R3 dwell restart
    refCode = 10'd100;
    restart();
    setFb(100); pulseUs(DWELL - 1);
    setFb(110); pulseUs(1);
    setFb(100); pulseUs(DWELL - 1);
    check("R3 restart no early rise", pgOut, 1'b0);
    pulseUs(1);
    check("R3 rise after full dwell", pgOut, 1'b1);

    // R5 excursion count reset on return
    setFb(120); pulseCyc(1);
    setFb(100); pulseCyc(1);
    setFb(120); pulseCyc(1);
    check("R5 count reset on return", pgOut, 1'b1);
    pulseCyc(1);
    check("R5 clear after second tick", pgOut, 1'b0);

    // R6 display select
    restart(); dispSel = 1'b0;
    setFb(100); pulseUs(DWELL);
    check("R6 pin quiet without dispSel", intPin, 1'b0);
    dispSel = 1'b1; waitN(1);
    check("R6 pin shows pg", intPin, 1'b1);
    restart();
    check("R6 pin follows pg low", intPin, 1'b0);

    // R7 startup hold
    dispSel = 1'b0; startup = 1'b1; waitN(1);
    check("R7 startup holds pin", intPin, 1'b1);
    pulseUs(DWELL - 1);
    check("R7 still held", intPin, 1'b1);
    pulseUs(1);
    check("R7 released once qualified", intPin, 1'b0);
    startup = 1'b0;

    // R8 mask
    restart(); dispSel = 1'b1; mask = 1'b1;
    setFb(100); pulseUs(DWELL);
    check("R8 masked pgOut", pgOut, 1'b0);
    check("R8 masked intPin", intPin, 1'b0);
    mask = 1'b0; waitN(1);
    check("R8 unmask shows state", pgOut, 1'b1);
    check("R8 unmask shows pin", intPin, 1'b1);

    // R9 enable low clears
    enable = 1'b0; waitN(1);
    check("R9 disable clears", pgOut, 1'b0);
    enable = 1'b1; waitN(1);
    check("R9 stays clear after enable", pgOut, 1'b0);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule